// File: doc/BRIEF.md
# Bidirectional GPIO Port with Switchable Pulldowns

This block is a small parallel I/O port that a processor controls through four byte-wide registers on a simple register bus. Each pin is built from the same slice. A direction bit turns the pin's pad driver on or off. A data latch holds the value that is driven out. A read of the data register returns one of two things per pin: the latch contents for an output pin, or the synchronised pad level for an input pin. The latch takes a write at any time, so software can set up a value before it turns the pin into an output.

Each input pin has a weak pulldown. Software can turn off all pulldowns at once with a global disable bit. It can also turn off single pulldowns through a write-only inhibit register.

One pin, chosen by a parameter, can be taken over for an oscillator. This happens when two mode bits are both set. In that mode the pin's GPIO driver and pulldown are off, and the external oscillator signal is routed onto that pin's output value line. The pin's direction and data bits still read and write as plain storage while the takeover is active.

Top module: `gpio_port`

## Requirements
- R1: For a pin whose direction bit is 1, a read of the data register (address 0) returns that pin's data latch bit and not the pad level.
- R2: For a pin whose direction bit is 0, a read of the data register returns the pad level. The pad level is captured through two flip-flops, so a change on `pin_in` becomes readable after the second rising clock edge.
- R3: A write to address 0 updates the data latch on the next clock edge, whatever the direction bits hold.
- R4: `pad_pd_en[i]` is 1 exactly when pin i is an input, the global disable (control bit 0) is 0, and the inhibit bit i is 0. A driven pin never has its pulldown enabled.
- R5: The inhibit register at address 2 can be written, but a read of that address always returns 0.
- R6: When control bit 1 (RC select) and control bit 2 (three-pin select) are both 1, the oscillator pin has `pad_oe` at 0 and `pad_pd_en` at 0, and its `pad_out` follows `osc_in`. With any other combination of those two bits, the pin behaves as an ordinary GPIO pin.
- R7: While the oscillator takeover is active, the oscillator pin's direction bit and data bit can still be written and read back.
- R8: A synchronous active-low reset clears the direction register (all pins become inputs), the inhibit register and the control register. Reset leaves the data latch unchanged.
- R9: Outside the takeover, `pad_oe` equals the direction register and `pad_out` equals the data latch.
- R10: The control register at address 3 reads back bits 2:0 as written, and its upper bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 data, 1 direction, 2 pulldown inhibit, 3 control |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Combinational read data for `bus_addr` |
| pin_in | input | WIDTH | Pad input levels (asynchronous) |
| osc_in | input | 1 | Oscillator output to be routed to the takeover pin |
| pad_oe | output | WIDTH | Per-pin output driver enable |
| pad_out | output | WIDTH | Per-pin output value |
| pad_pd_en | output | WIDTH | Per-pin pulldown enable |

## Verification
The bench builds the port with WIDTH=4 and OSC_PIN=1. At this width every combination of direction, latch and pad level can be swept, which is 4096 cases. Every combination of direction, inhibit mask and global disable is also swept, which is 512 cases. With only 16 values per register, the read mux and the pulldown gate are checked over their whole input space, not just a sample of it. Putting the takeover on an inner pin shows that the takeover touches only that bit, while pins on both sides keep their ordinary GPIO behaviour.

// File: rtl/gpio_port_pkg.sv
// Shared register selectors and control bit positions for the GPIO port.
// Assumes a two-bit register address.
package gpio_port_pkg;
    typedef enum logic [1:0] {
        REG_DATA  = 2'd0,
        REG_DIR   = 2'd1,
        REG_PDINH = 2'd2,
        REG_CTRL  = 2'd3
    } reg_sel_e;

    localparam int CTRL_PDOFF = 0;
    localparam int CTRL_RC    = 1;
    localparam int CTRL_3PIN  = 2;
    localparam int CTRL_BITS  = 3;
endpackage

// File: rtl/gpio_port_sync.sv
// Two-flop synchroniser for the pad input levels.
// Assumes pin_in is asynchronous to clk. Both stages clear on reset.
module gpio_port_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Shift the pad levels through two register stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

    AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (stage2_q == $past(stage1_q))); // R2
endmodule

// File: rtl/gpio_port_regs.sv
// Register file for the port: data latch, direction, pulldown inhibit, control.
// Assumes writes are single-cycle strobes. The data latch has no reset.
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  reg_sel_e         sel,
    input  logic             we,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] latch_q,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] inh_q,
    output logic [CTRL_BITS-1:0] ctrl_q
);
    // Data latch: written whenever addressed, independent of direction and reset.
    always_ff @(posedge clk) begin
        if (rst_n && we && sel == REG_DATA) begin
            latch_q <= wdata;
        end
    end

    // Direction, inhibit and control registers with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            inh_q  <= '0;
            ctrl_q <= '0;
        end else if (we) begin
            case (sel)
                REG_DIR:   dir_q  <= wdata;
                REG_PDINH: inh_q  <= wdata;
                REG_CTRL:  ctrl_q <= wdata[CTRL_BITS-1:0];
                default:   ;
            endcase
        end
    end

    AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == REG_DATA) |=> (latch_q == $past(wdata))); // R3
    AST_DIR_RESET: assert property (@(posedge clk)
        !rst_n |=> (dir_q == '0 && inh_q == '0 && ctrl_q == '0)); // R8
endmodule

// File: rtl/gpio_port_slice.sv
// One pin: output driver control, pulldown gate and read-back selection.
// Assumes pin_sync is already synchronised. The takeover input forces the
// pin off the GPIO driver and pulldown and selects alt_out as the output value.
module gpio_port_slice (
    input  logic clk,
    input  logic rst_n,
    input  logic dir,
    input  logic latch,
    input  logic inh,
    input  logic pd_off,
    input  logic takeover,
    input  logic alt_out,
    input  logic pin_sync,
    output logic oe,
    output logic out,
    output logic pd_en,
    output logic rd_bit
);
    // Driver enable and output value, overridden during takeover.
    always_comb begin
        oe  = dir & ~takeover;
        out = takeover ? alt_out : latch;
    end

    // Pulldown only on an undriven pin with neither disable set.
    always_comb begin
        pd_en = ~dir & ~pd_off & ~inh & ~takeover;
    end

    // Output pins read their latch, input pins their synchronised level.
    always_comb begin
        rd_bit = dir ? latch : pin_sync;
    end

    AST_PD_NOT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> !pd_en); // R4
endmodule

// File: rtl/gpio_port.sv
// Top of the GPIO port: register bus decode, per-pin slices and read mux.
// Assumes OSC_PIN < WIDTH and WIDTH >= 3, so the control bits fit the bus.
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int WIDTH   = 8,
    parameter int OSC_PIN = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_addr,
    input  logic             bus_we,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    input  logic [WIDTH-1:0] pin_in,
    input  logic             osc_in,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_pd_en
);
    localparam int CTRL_PAD = WIDTH - CTRL_BITS;

    reg_sel_e             sel;
    logic [WIDTH-1:0]     latch_q;
    logic [WIDTH-1:0]     dir_q;
    logic [WIDTH-1:0]     inh_q;
    logic [CTRL_BITS-1:0] ctrl_q;
    logic [WIDTH-1:0]     pin_sync;
    logic [WIDTH-1:0]     data_rd;
    logic                 osc_mode;

    assign sel      = reg_sel_e'(bus_addr);
    assign osc_mode = ctrl_q[CTRL_RC] & ctrl_q[CTRL_3PIN];

    gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .we      (bus_we),
        .wdata   (bus_wdata),
        .latch_q (latch_q),
        .dir_q   (dir_q),
        .inh_q   (inh_q),
        .ctrl_q  (ctrl_q)
    );

    gpio_port_sync #(.WIDTH(WIDTH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        logic take;
        logic alt;
        if (i == OSC_PIN) begin : g_osc
            assign take = osc_mode;
            assign alt  = osc_in;
        end else begin : g_gpio
            assign take = 1'b0;
            assign alt  = 1'b0;
        end
        gpio_port_slice u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .dir      (dir_q[i]),
            .latch    (latch_q[i]),
            .inh      (inh_q[i]),
            .pd_off   (ctrl_q[CTRL_PDOFF]),
            .takeover (take),
            .alt_out  (alt),
            .pin_sync (pin_sync[i]),
            .oe       (pad_oe[i]),
            .out      (pad_out[i]),
            .pd_en    (pad_pd_en[i]),
            .rd_bit   (data_rd[i])
        );
    end

    // Read-back mux: the inhibit register is write-only and reads as zero.
    always_comb begin
        case (sel)
            REG_DATA:  bus_rdata = data_rd;
            REG_DIR:   bus_rdata = dir_q;
            REG_CTRL:  bus_rdata = {{CTRL_PAD{1'b0}}, ctrl_q};
            default:   bus_rdata = '0;
        endcase
    end

    AST_INH_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == REG_PDINH) |-> (bus_rdata == '0)); // R5
    AST_OSC_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        osc_mode |-> (!pad_oe[OSC_PIN] && !pad_pd_en[OSC_PIN] && pad_out[OSC_PIN] == osc_in)); // R6
endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
    localparam int W   = 4;
    localparam int OSC = 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   bus_addr = 2'd0;
    logic         bus_we = 1'b0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic [W-1:0] pin_in = '0;
    logic         osc_in = 1'b0;
    logic [W-1:0] pad_oe;
    logic [W-1:0] pad_out;
    logic [W-1:0] pad_pd_en;

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    gpio_port #(.WIDTH(W), .OSC_PIN(OSC)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .osc_in    (osc_in),
        .pad_oe    (pad_oe),
        .pad_out   (pad_out),
        .pad_pd_en (pad_pd_en)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        logic [W-1:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        wr(2'd0, 4'hA);
        wr(2'd1, 4'h5);
        wr(2'd2, 4'h3);
        wr(2'd3, 4'h7);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        rd(2'd1, r); check("R8 dir reset", r, 4'h0);
        rd(2'd3, r); check("R8 ctrl reset", r, 4'h0);
        check("R8 pulldowns on after reset", pad_pd_en, 4'hF);
        check("R8 no drivers after reset", pad_oe, 4'h0);
        wr(2'd1, 4'hF);
        rd(2'd0, r); check("R8 latch kept over reset", r, 4'hA);

        // Full sweep of direction, latch and pad level
        for (int d = 0; d < 16; d++) begin
            for (int l = 0; l < 16; l++) begin
                wr(2'd1, W'(d));
                wr(2'd0, W'(l));
                pin_in = ~W'(l);
                for (int p = 0; p < 16; p++) begin
                    pin_in = W'(p);
                    @(negedge clk); @(negedge clk);
                    rd(2'd0, r);
                    check("R1 R2 R3 data read", r, (W'(l) & W'(d)) | (W'(p) & ~W'(d)));
                end
                check("R9 pad_oe", pad_oe, W'(d));
                check("R9 pad_out", pad_out, W'(l));
            end
        end

        // Full sweep of the pulldown gate
        for (int d = 0; d < 16; d++) begin
            for (int h = 0; h < 16; h++) begin
                for (int g = 0; g < 2; g++) begin
                    wr(2'd1, W'(d));
                    wr(2'd2, W'(h));
                    wr(2'd3, W'(g));
                    check("R4 pulldown", pad_pd_en, ~W'(d) & ~W'(h) & {W{g == 0}});
                    rd(2'd2, r); check("R5 inhibit reads zero", r, 4'h0);
                end
            end
        end

        for (int c = 0; c < 16; c++) begin
            wr(2'd3, W'(c));
            rd(2'd3, r); check("R10 ctrl readback", r, W'(c) & 4'h7);
        end

        // Oscillator takeover under each mode-bit combination
        wr(2'd2, 4'h0);
        wr(2'd0, 4'h0);
        for (int m = 0; m < 4; m++) begin
            bit on;
            on = (m == 3);
            wr(2'd3, W'(m << 1));
            wr(2'd1, 4'h0);
            check("R6 pulldown in mode", pad_pd_en, on ? 4'b1101 : 4'b1111);
            wr(2'd1, 4'hF);
            check("R6 driver in mode", pad_oe, on ? 4'b1101 : 4'b1111);
            for (int o = 0; o < 2; o++) begin
                @(negedge clk); osc_in = o[0]; #1;
                check("R6 osc routed", pad_out, on ? W'(o << OSC) : 4'h0);
            end
        end
        wr(2'd1, 4'h5);
        rd(2'd1, r); check("R7 dir storage in osc mode", r, 4'h5);
        wr(2'd1, 4'hF);
        wr(2'd0, 4'h6);
        rd(2'd0, r); check("R7 data storage in osc mode", r, 4'h6);

        done = 1'b1;
        finish_run();
    end
endmodule